// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters into asynchronous serial frames on a single transmit line. A character is taken through a valid/ready handshake. The block then sends it as a low start bit, followed by 5 to 8 data bits sent least significant bit first. An optional parity bit comes next, and the frame ends with one or two high stop bits. Between frames the line rests high. Bit timing comes from an external oversampling tick: every bit lasts sixteen ticks, so the baud-rate divider sits outside this block.

A set of line-control inputs chooses the frame format: word length, parity on or off, odd or even parity, stick parity, a second stop bit, and a break request. The format is captured when a character is accepted, so changing the inputs part way through a frame does not alter that frame. A break request lets the frame in progress finish. The line is then held low, and no new characters are accepted until the request is withdrawn.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, `busy` is low and `ch_ready` is high. With all line-control inputs at zero, the format is 5 data bits, no parity, one stop bit and no break.
- R2: A frame is a low start bit, then the data bits least significant first, then the stop bit(s), which are high. Each bit lasts exactly 16 cycles in which `tick_en` is high.
- R3: `lc_wlen` sets the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the chosen width are not sent.
- R4: When `lc_par_en`=1 and `lc_stick`=0, one parity bit follows the data. With `lc_even`=1 it makes the number of ones in data plus parity even. With `lc_even`=0 it makes that number odd.
- R5: When `lc_par_en`=1 and `lc_stick`=1, the parity bit is fixed: 1 when `lc_even`=0 and 0 when `lc_even`=1.
- R6: When `lc_par_en`=0 the frame has no parity bit, whatever `lc_even` and `lc_stick` are set to.
- R7: `lc_two_stop`=1 sends two stop bits. Otherwise one stop bit is sent.
- R8: When `lc_break` is high, the character being sent is completed first. After that the line is held low and `ch_ready` stays low.
- R9: When `lc_break` goes low, the line returns high, `ch_ready` comes back and normal frames can be sent again.
- R10: The line-control inputs are captured when a character is accepted. Changing them during a frame has no effect on that frame.
- R11: A character is taken only in a cycle where both `ch_valid` and `ch_ready` are high. From the next cycle, `busy` stays high until the last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oversampling tick, 16 per bit |
| lc_wlen | input | 2 | Word length select |
| lc_par_en | input | 1 | Parity enable |
| lc_even | input | 1 | Even parity select |
| lc_stick | input | 1 | Stick parity select |
| lc_two_stop | input | 1 | Second stop bit select |
| lc_break | input | 1 | Break request |
| ch_valid | input | 1 | Character offered |
| ch_data | input | 8 | Character value |
| ch_ready | output | 1 | Character can be taken |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame or break in progress |

## Verification
The line and `busy` are registered from the next state, so the start bit appears one cycle after the accepting edge. In the bench a tick arrives on every second cycle, which makes each bit 32 cycles long. The first bit may be one cycle shorter, depending on the tick phase at acceptance. The monitor waits for the falling edge of the start bit. It samples 16 cycles later, near the middle of the start bit, and then every 32 cycles, comparing each sample with the bit list the driver queued. The break checks wait until the monitor has seen the interrupted frame's stop bits. Only then do they expect a low line, and they expect a high line three cycles after the request is withdrawn.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even;
    logic       stick;
    logic       two_stop;
  } line_ctl_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP1 = 3'd4,
    S_STOP2 = 3'd5,
    S_BRK   = 3'd6
  } tx_state_t;

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt;

  assign bit_end = tick && (cnt == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // a bit period always closes by wrapping the counter to zero
  assert_timer_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == LAST && !restart) |=> (cnt == '0));

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              even,
  input  logic              stick,
  output logic              par_bit
);
  localparam int MIN_W = DATA_W - 3;

  logic [DATA_W-1:0] keep;
  logic              xr;

  // bit b is kept when b < MIN_W + wlen
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b < MIN_W) begin : g_fixed
      assign keep[b] = data[b];
    end else begin : g_sel
      assign keep[b] = data[b] && (int'(wlen) > (b - MIN_W));
    end
  end

  assign xr = ^keep;

  always_comb begin
    if (!par_en)     par_bit = 1'b0;
    else if (stick)  par_bit = !even;
    else             par_bit = even ? xr : !xr;
  end

endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_end,
  input  logic              brk_req,
  input  line_ctl_t         lc_in,
  input  logic              par_in,
  input  logic              ch_valid,
  input  logic [DATA_W-1:0] ch_data,
  output logic              ch_ready,
  output logic              accept,
  output logic              tx_line,
  output logic              busy
);
  localparam int MIN_W = DATA_W - 3;
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_t         state, state_n;
  line_ctl_t         lc_q;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [IDX_W-1:0]  idx_q, idx_n, last_idx;
  logic              par_q;
  logic              line_n;

  assign ch_ready = (state == S_IDLE) && !brk_req;
  assign accept   = ch_valid && ch_ready;
  assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(lc_q.wlen);

  always_comb begin
    state_n = state;
    sh_n    = sh_q;
    idx_n   = idx_q;
    unique case (state)
      S_IDLE: begin
        if (brk_req) state_n = S_BRK;
        else if (ch_valid) begin
          state_n = S_START;
          sh_n    = ch_data;
        end
      end
      S_START: if (bit_end) begin
        state_n = S_DATA;
        idx_n   = '0;
      end
      S_DATA: if (bit_end) begin
        sh_n = sh_q >> 1;
        if (idx_q == last_idx) state_n = lc_q.par_en ? S_PAR : S_STOP1;
        else                   idx_n   = idx_q + 1'b1;
      end
      S_PAR: if (bit_end) state_n = S_STOP1;
      S_STOP1: if (bit_end) begin
        if (lc_q.two_stop) state_n = S_STOP2;
        else               state_n = brk_req ? S_BRK : S_IDLE;
      end
      S_STOP2: if (bit_end) state_n = brk_req ? S_BRK : S_IDLE;
      S_BRK: if (!brk_req) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_n)
      S_START, S_BRK: line_n = 1'b0;
      S_DATA:         line_n = sh_n[0];
      S_PAR:          line_n = par_q;
      default:        line_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      lc_q    <= '0;
      par_q   <= 1'b0;
      tx_line <= 1'b1;
      busy    <= 1'b0;
    end else begin
      state   <= state_n;
      sh_q    <= sh_n;
      idx_q   <= idx_n;
      tx_line <= line_n;
      busy    <= (state_n != S_IDLE);
      if (accept) begin
        lc_q  <= lc_in;
        par_q <= par_in;
      end
    end
  end

  // captured format stays put for the whole frame
  assert_fields_held_R10: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(lc_q));

  // break is only entered from idle or at the end of a stop bit
  assert_break_between_frames_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_BRK && $past(state) != S_BRK) |->
      ($past(state) == S_IDLE || $past(state) == S_STOP1 || $past(state) == S_STOP2));

  // stop bits and idle keep the line high
  assert_stop_high_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP1 || state == S_STOP2 || state == S_IDLE) |-> tx_line);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [1:0]        lc_wlen,
  input  logic              lc_par_en,
  input  logic              lc_even,
  input  logic              lc_stick,
  input  logic              lc_two_stop,
  input  logic              lc_break,
  input  logic              ch_valid,
  input  logic [DATA_W-1:0] ch_data,
  output logic              ch_ready,
  output logic              tx_line,
  output logic              busy
);
  line_ctl_t lc_in;
  logic      par_in, bit_end, accept;

  assign lc_in = '{wlen: lc_wlen, par_en: lc_par_en, even: lc_even,
                   stick: lc_stick, two_stop: lc_two_stop};

  uart_tx_bit_timer #(.OSR(OSR)) i_timer (
    .clk(clk), .rst(rst), .restart(accept), .tick(tick_en), .bit_end(bit_end)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) i_par (
    .data(ch_data), .wlen(lc_wlen), .par_en(lc_par_en), .even(lc_even),
    .stick(lc_stick), .par_bit(par_in)
  );

  uart_tx_sequencer #(.DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst(rst), .bit_end(bit_end), .brk_req(lc_break),
    .lc_in(lc_in), .par_in(par_in), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .accept(accept), .tx_line(tx_line), .busy(busy)
  );

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && ch_ready) |=> busy);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_line);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  logic       clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
  logic [1:0] lc_wlen = 2'b00;
  logic       lc_par_en = 0, lc_even = 0, lc_stick = 0, lc_two_stop = 0, lc_break = 0;
  logic       ch_valid = 0;
  logic [7:0] ch_data = '0;
  logic       ch_ready, tx_line, busy;

  int n_checks = 0, n_fails = 0, frames_done = 0, cyc = 0;
  int    exp_bits[$];
  int    exp_len[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst(rst), .tick_en(tick_en), .lc_wlen(lc_wlen),
    .lc_par_en(lc_par_en), .lc_even(lc_even), .lc_stick(lc_stick),
    .lc_two_stop(lc_two_stop), .lc_break(lc_break), .ch_valid(ch_valid),
    .ch_data(ch_data), .ch_ready(ch_ready), .tx_line(tx_line), .busy(busy)
  );

  initial forever begin
    @(negedge clk);
    tick_en = ~tick_en;
    cyc++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // driver: program format, hand over a character, queue the expected frame
  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                      input logic ev, input logic st, input logic two, input string tag);
    int nb, ones, p;
    @(negedge clk);
    lc_wlen = wl; lc_par_en = pe; lc_even = ev; lc_stick = st; lc_two_stop = two;
    ch_data = d; ch_valid = 1'b1;
    nb = 5 + int'(wl);
    ones = 0;
    exp_bits.push_back(0);
    for (int i = 0; i < nb; i++) begin
      exp_bits.push_back(int'(d[i]));
      ones += int'(d[i]);
    end
    if (pe) begin
      if (st) p = ev ? 0 : 1;
      else    p = ev ? (ones % 2) : 1 - (ones % 2);
      exp_bits.push_back(p);
    end
    exp_bits.push_back(1);
    if (two) exp_bits.push_back(1);
    exp_len.push_back(1 + nb + int'(pe) + 1 + int'(two));
    exp_tag.push_back(tag);
    forever begin
      @(posedge clk);
      if (ch_ready) break;
    end
    @(negedge clk);
    ch_valid = 1'b0;
    ch_data  = 8'hxx;
  endtask

  // monitor: find start edge, sample mid-bit every 32 cycles
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (prev && !tx_line && exp_len.size() > 0) begin
        int n;
        string tg;
        n  = exp_len.pop_front();
        tg = exp_tag.pop_front();
        repeat (15) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          check({tg, " bit"}, int'(tx_line), exp_bits.pop_front());
          check("R11 busy mid-frame", int'(busy), 1);
          if (i < n - 1) repeat (32) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        frames_done++;
      end
      prev = tx_line;
    end
  end

  initial begin
    wait (cyc > 150000);
    check("watchdog", 0, 1);
    finish_run();
  end

  task automatic drain();
    wait (exp_len.size() == 0);
    wait (busy == 1'b0);
    @(negedge clk);
  endtask

  initial begin
    int fd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_line", int'(tx_line), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 ch_ready", int'(ch_ready), 1);

    // R1 default format, R2 basic framing
    send(8'hE5, 2'b00, 0, 0, 0, 0, "R1 default 5-bit");
    // R3 each word length, back to back (R10: fields change mid-frame)
    send(8'hA6, 2'b01, 0, 0, 0, 0, "R3 6-bit / R10");
    send(8'h5B, 2'b10, 0, 0, 0, 0, "R3 7-bit / R10");
    send(8'h96, 2'b11, 0, 0, 0, 0, "R3 8-bit / R2");
    // R4 even and odd parity
    send(8'h37, 2'b11, 1, 1, 0, 0, "R4 even parity");
    send(8'h37, 2'b11, 1, 0, 0, 0, "R4 odd parity");
    send(8'h1C, 2'b00, 1, 1, 0, 0, "R4 even 5-bit");
    // R5 stick parity
    send(8'hFF, 2'b11, 1, 0, 1, 0, "R5 stick one");
    send(8'hFE, 2'b11, 1, 1, 1, 0, "R5 stick zero");
    // R6 parity disabled ignores even/stick
    send(8'h0F, 2'b11, 0, 1, 1, 0, "R6 no parity");
    // R7 two stop bits
    send(8'h81, 2'b11, 1, 1, 0, 1, "R7 two stops");
    send(8'h44, 2'b10, 0, 0, 0, 1, "R7 two stops no par");
    drain();
    check("R11 busy after frames", int'(busy), 0);
    check("R11 ready after frames", int'(ch_ready), 1);

    // R8 break mid-frame: character completes, then line low
    send(8'h00, 2'b11, 0, 0, 0, 0, "R8 frame before break");
    fd = frames_done;
    repeat (40) @(negedge clk);
    lc_break = 1'b1;
    check("R8 line not forced low mid-frame", int'(busy), 1);
    wait (frames_done == fd + 1);
    repeat (30) @(negedge clk);
    check("R8 line low in break", int'(tx_line), 0);
    check("R8 ready low in break", int'(ch_ready), 0);
    ch_valid = 1'b1; ch_data = 8'h55;
    repeat (100) @(negedge clk);
    check("R8 no accept during break", int'(tx_line), 0);
    check("R8 ready still low", int'(ch_ready), 0);
    ch_valid = 1'b0;
    // R9 release
    lc_break = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 line high after break", int'(tx_line), 1);
    check("R9 ready after break", int'(ch_ready), 1);
    send(8'hC3, 2'b11, 1, 0, 0, 1, "R9 frame after break");
    drain();
    finish_run();
  end
endmodule